// File: doc/BRIEF.md
# Serial Device-ID Readout Shifter

This block returns a fixed per-device identifier to a host one bit per read access. A reload strobe loads a shift register with two fields. The first is an 8-bit length field that holds the identifier width. The second is the identifier itself. Both fields go out most significant bit first.

The current bit appears in bit 0 of an 8-bit read value, and the upper bits read as zero. A host can therefore rebuild each field by shifting its accumulator left one place and adding every value it reads. The identifier comes in on a parallel input that stands in for the on-chip ID primitive. The length field is derived from the identifier-width parameter, so software can handle identifiers of any size.

After the last identifier bit has been read, the stream returns zeros until the next reload. A reload may be issued at any point, including in the middle of a stream.

Top module: `devid_stream`

## Requirements
- R1: The identifier width is a parameter (default 57). The length field is 8 bits wide and holds that width as an unsigned number, so by default it reads back as 57.
- R2: The first eight reads after a reload return the length field, most significant bit first.
- R3: Bits 7:1 of `readData` are always zero. The current stream bit is on bit 0.
- R4: Each cycle with `readStb` high advances the stream by one bit. With neither strobe high, `readData` holds its value.
- R5: The next identifier-width reads after the length field return the identifier from `idValue`, most significant bit first.
- R6: Once every length and identifier bit has been read, further reads return 0 until the next reload.
- R7: If `reloadStb` and `readStb` are high in the same cycle, the reload wins. The next read returns the first length bit.
- R8: After reset and before any reload, `readData` is 0.
- R9: A reload in the middle of a stream restarts the stream from the first length bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reloadStb | input | 1 | One-cycle pulse that reloads the stream |
| readStb | input | 1 | One-cycle pulse for each host read; advances the stream |
| idValue | input | ID_WIDTH | Parallel device identifier (models the ID primitive) |
| readData | output | 8 | Read value; the current stream bit is in bit 0 |

## Verification
Four properties are checked on every clock cycle:
- the upper read bits stay zero;
- `readData` is stable whenever no strobe is present;
- the first length bit appears after every reload, including one that coincides with a read;
- the output is zero once a read counter kept in the checker shows that the stream is exhausted.

Only the bench scenarios can show that the whole bit order is correct for two different identifiers. The same holds for the length value a host rebuilds and for a restart from the middle of a stream.

// File: rtl/devid_stream_pkg.sv
package devid_stream_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture length field and identifier
    logic shift;  // advance one bit
  } shiftCmd_t;
endpackage

// File: rtl/devid_stream_ctrl.sv
module devid_stream_ctrl
  import devid_stream_pkg::*;
#(
  parameter int TOTAL_BITS = 65
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reloadStb,
  input  logic      readStb,
  output shiftCmd_t cmd
);
  localparam int CNT_W = $clog2(TOTAL_BITS + 1);

  logic [CNT_W-1:0] bitsLeft;

  // Reload has priority; shifting stops once the stream is used up
  always_comb begin
    cmd.load  = reloadStb;
    cmd.shift = readStb && !reloadStb && (bitsLeft != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          bitsLeft <= '0;
    else if (cmd.load)  bitsLeft <= CNT_W'(TOTAL_BITS);
    else if (cmd.shift) bitsLeft <= bitsLeft - 1'b1;
  end
endmodule

// File: rtl/devid_stream_dp.sv
module devid_stream_dp
  import devid_stream_pkg::*;
#(
  parameter int ID_WIDTH   = 57,
  parameter int LEN_WIDTH  = 8,
  parameter int DATA_WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  shiftCmd_t             cmd,
  input  logic [ID_WIDTH-1:0]   idValue,
  output logic [DATA_WIDTH-1:0] readData
);
  localparam int TOTAL_BITS = LEN_WIDTH + ID_WIDTH;
  localparam logic [LEN_WIDTH-1:0] LEN_VAL = LEN_WIDTH'(ID_WIDTH);

  logic [TOTAL_BITS-1:0] streamReg;

  // Zeros shift in from the bottom, so an exhausted stream reads 0
  always_ff @(posedge clk) begin
    if (!rstN)          streamReg <= '0;
    else if (cmd.load)  streamReg <= {LEN_VAL, idValue};
    else if (cmd.shift) streamReg <= {streamReg[TOTAL_BITS-2:0], 1'b0};
  end

  assign readData = {{(DATA_WIDTH-1){1'b0}}, streamReg[TOTAL_BITS-1]};
endmodule

// File: rtl/devid_stream.sv
module devid_stream
  import devid_stream_pkg::*;
#(
  parameter int ID_WIDTH   = 57,
  parameter int LEN_WIDTH  = 8,
  parameter int DATA_WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reloadStb,
  input  logic                  readStb,
  input  logic [ID_WIDTH-1:0]   idValue,
  output logic [DATA_WIDTH-1:0] readData
);
  localparam int TOTAL_BITS = LEN_WIDTH + ID_WIDTH;

  shiftCmd_t cmd;

  devid_stream_ctrl #(.TOTAL_BITS(TOTAL_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .reloadStb(reloadStb), .readStb(readStb), .cmd(cmd)
  );

  devid_stream_dp #(
    .ID_WIDTH(ID_WIDTH), .LEN_WIDTH(LEN_WIDTH), .DATA_WIDTH(DATA_WIDTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .idValue(idValue), .readData(readData)
  );
endmodule

// File: rtl/devid_stream_chk.sv
module devid_stream_chk #(
  parameter int ID_WIDTH   = 57,
  parameter int LEN_WIDTH  = 8,
  parameter int DATA_WIDTH = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reloadStb,
  input logic                  readStb,
  input logic [DATA_WIDTH-1:0] readData
);
  localparam int TOTAL_BITS = LEN_WIDTH + ID_WIDTH;
  localparam int CNT_W = $clog2(TOTAL_BITS + 1);
  localparam logic [LEN_WIDTH-1:0] LEN_VAL = LEN_WIDTH'(ID_WIDTH);
  localparam logic LEN_MSB = LEN_VAL[LEN_WIDTH-1];

  // Reads taken since the last reload, saturating; starts exhausted
  logic [CNT_W-1:0] readsDone;
  always_ff @(posedge clk) begin
    if (!rstN)                   readsDone <= CNT_W'(TOTAL_BITS);
    else if (reloadStb)          readsDone <= '0;
    else if (readStb && readsDone != CNT_W'(TOTAL_BITS))
                                 readsDone <= readsDone + 1'b1;
  end

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    readData[DATA_WIDTH-1:1] == '0);

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!readStb && !reloadStb) |=> $stable(readData));

  assert_first_len_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    reloadStb |=> readData[0] == LEN_MSB);

  assert_reload_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reloadStb && readStb) |=> (readData[0] == LEN_MSB));

  assert_drained_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (readsDone == CNT_W'(TOTAL_BITS)) |-> (readData == '0));
endmodule

bind devid_stream devid_stream_chk #(
  .ID_WIDTH(ID_WIDTH), .LEN_WIDTH(LEN_WIDTH), .DATA_WIDTH(DATA_WIDTH)
) uChk (
  .clk(clk), .rstN(rstN), .reloadStb(reloadStb), .readStb(readStb), .readData(readData)
);

// File: tb/sim_devid_stream.sv
`timescale 1ns/1ps
module sim_devid_stream;
  localparam int IDW   = 57;
  localparam int LENW  = 8;
  localparam int TOTAL = LENW + IDW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reloadStb = 1'b0;
  logic readStb = 1'b0;
  logic [IDW-1:0] idValue = 57'h1_3579_BDF0_2468_A;
  logic [7:0] readData;

  int total = 0;
  int bad = 0;

  logic [7:0] expQ[$];
  string tagQ[$];
  event sampleEv;

  always #4 clk = ~clk;

  devid_stream u0 (
    .clk(clk), .rstN(rstN), .reloadStb(reloadStb), .readStb(readStb),
    .idValue(idValue), .readData(readData)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected bit k of the stream, built from the requirements
  function automatic logic expBit(input int k, input logic [IDW-1:0] id);
    logic [LENW-1:0] lenVal;
    lenVal = LENW'(IDW);
    if (k < LENW) return lenVal[LENW-1-k];
    if (k < TOTAL) return id[IDW-1-(k-LENW)];
    return 1'b0;
  endfunction

  function automatic string tagFor(input int k);
    if (k < LENW) return "R2";
    if (k < TOTAL) return "R5";
    return "R6";
  endfunction

  // Monitor: pops and compares expectations
  initial begin
    forever begin
      @(sampleEv);
      check(readData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  // Driver: one read access; expectation pushed, sample 1 ns after negedge
  task automatic readOne(input logic [7:0] e, input string tag, input logic withReload,
                         output logic [7:0] got);
    @(negedge clk);
    readStb = 1'b1;
    reloadStb = withReload;
    expQ.push_back(e);
    tagQ.push_back(tag);
    #1;
    got = readData;
    ->sampleEv;
    @(negedge clk);
    readStb = 1'b0;
    reloadStb = 1'b0;
  endtask

  task automatic reload();
    @(negedge clk);
    reloadStb = 1'b1;
    @(negedge clk);
    reloadStb = 1'b0;
  endtask

  task automatic readRange(input int fromK, input int toK, input logic [IDW-1:0] id,
                           input string prefix);
    logic [7:0] g;
    for (int k = fromK; k < toK; k++)
      readOne({7'b0, expBit(k, id)}, {prefix, tagFor(k)}, 1'b0, g);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] g;
    logic [7:0] lenAcc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(readData, 8'h00, "R8 reset");
    readOne(8'h00, "R8 read before reload", 1'b0, g);
    readOne(8'h00, "R8 read before reload", 1'b0, g);

    // Full stream, length rebuilt by left-shift accumulation (R1)
    reload();
    lenAcc = '0;
    for (int k = 0; k < LENW; k++) begin
      readOne({7'b0, expBit(k, idValue)}, "R2 len", 1'b0, g);
      lenAcc = {lenAcc[6:0], 1'b0} + g;
    end
    check(lenAcc, 8'd57, "R1 length value");
    readRange(LENW, TOTAL + 3, idValue, "full ");

    // Hold when idle mid-stream (R4)
    reload();
    readRange(0, 3, idValue, "R4 pre ");
    repeat (4) @(negedge clk);
    check(readData, {7'b0, expBit(3, idValue)}, "R4 idle hold");
    readRange(3, 5, idValue, "R4 post ");

    // Mid-stream reload restarts (R9)
    reload();
    readRange(0, 20, idValue, "R9 pre ");
    reload();
    readRange(0, TOTAL + 1, idValue, "R9 restart ");

    // Reload and read together: reload wins (R7)
    reload();
    readRange(0, 10, idValue, "R7 pre ");
    readOne({7'b0, expBit(10, idValue)}, "R7 coincident", 1'b1, g);
    readRange(0, 12, idValue, "R7 after ");

    // Second identifier pattern (R5)
    idValue = 57'h0AA_55AA_F00F_3C3C;
    reload();
    readRange(0, TOTAL + 2, idValue, "alt ");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule